// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits in front of a memory array that two independent ports share. Each port offers an enable, a write strobe and an address on one shared clock. When both ports are enabled on the same address, the block picks a winner and pulls the other port's active-low busy flag. A write from the losing port is stopped before it reaches the array. A read from the losing port still goes ahead.

Ties are broken by history. If one port was already enabled when the other became enabled on the same address, the earlier port wins. If both ports were already enabled and one moves its address onto the other's, the port that did not move wins. If neither history decides, the left port wins. The winner is kept for as long as the collision lasts.

A mode input selects between two roles. In lead mode the block drives its own busy flags. In follower mode it ignores its own collision logic and obeys busy flags that come from a lead device, which lets several devices share one wide word. Every result is registered, so the outputs show the decision one clock after the inputs that caused it. The array write strobe and read qualifier are the `*_wr_ok` and `*_rd_ok` outputs.

Top module: `dpcoll_arb`

## Requirements
- R1: In lead mode (`lead_sel`=1), a port's `*_busy_n` is low one cycle after a cycle in which both ports were enabled on equal addresses and that port lost, and at most one busy flag is low at a time.
- R2: In lead mode, both busy flags are high one cycle after any cycle with no collision, whether the addresses differ or one enable is low.
- R3: When a collision begins and exactly one port was enabled in the previous cycle, that port wins.
- R4: When a collision begins, both ports were enabled in the previous cycle, and only one port's address changed since then, the port whose address did not change wins.
- R5: When a collision begins and neither R3 nor R4 decides (both newly enabled, or both addresses changed), the left port wins.
- R6: While a collision lasts without a break, the winner chosen when it began is kept, even if the addresses later stop changing.
- R7: `*_wr_ok` is high one cycle after a cycle in which the port was enabled with its write strobe high and did not lose, and it is low whenever that port's busy flag is low.
- R8: `*_rd_ok` is high one cycle after a cycle in which the port was enabled with its write strobe low, whether or not the port lost.
- R9: In follower mode (`lead_sel`=0), each `*_busy_n` equals the value of its `*_hold_in_n` input one cycle earlier, internal collisions have no effect, and a low hold input blocks that port's write.
- R10: During reset both busy flags are high and all `*_wr_ok` and `*_rd_ok` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_sel | input | 1 | 1 = drive own busy flags, 0 = follow hold inputs |
| left_en | input | 1 | Left port enable |
| left_wr | input | 1 | Left port write strobe (0 = read) |
| left_addr | input | AW | Left port address |
| right_en | input | 1 | Right port enable |
| right_wr | input | 1 | Right port write strobe (0 = read) |
| right_addr | input | AW | Right port address |
| left_hold_in_n | input | 1 | Busy flag for the left port from a lead device (follower mode) |
| right_hold_in_n | input | 1 | Busy flag for the right port from a lead device (follower mode) |
| left_busy_n | output | 1 | Left port busy, active low |
| right_busy_n | output | 1 | Right port busy, active low |
| left_wr_ok | output | 1 | Qualified write strobe to the array, left port |
| right_wr_ok | output | 1 | Qualified write strobe to the array, right port |
| left_rd_ok | output | 1 | Qualified read to the array, left port |
| right_rd_ok | output | 1 | Qualified read to the array, right port |

## Verification
The busy flags and the write and read qualifiers all come from one rank of registers. Each of them therefore reflects the inputs of the cycle just before. The bench changes inputs on a falling edge and lets one rising edge pass. It then reads all six outputs at the next falling edge and compares them with a value it works out from the rules for that one input cycle. Decisions that depend on history (R3, R4, R6) are set up by a preceding cycle. The bench checks at every step so that holding and release are seen on the exact cycle they are due.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE  = 2'd0,
    SIDE_LEFT  = 2'd1,
    SIDE_RIGHT = 2'd2
  } side_e;

  // Both ports enabled on one address.
  function automatic logic addr_hit(input logic en_a, input logic en_b,
                                    input logic [63:0] a, input logic [63:0] b);
    return en_a && en_b && (a == b);
  endfunction

  // Winner of a collision that starts this cycle, from the previous cycle's history.
  function automatic side_e first_arrival(input logic l_was_en, input logic r_was_en,
                                          input logic l_moved, input logic r_moved);
    if (l_was_en && r_was_en) begin
      // address-match case: the port that stayed put got there first
      if (l_moved && !r_moved) return SIDE_RIGHT;
      return SIDE_LEFT;
    end
    // enable case: the port already enabled got there first
    if (r_was_en && !l_was_en) return SIDE_RIGHT;
    return SIDE_LEFT;
  endfunction

endpackage

// File: rtl/dpc_port_hist.sv
module dpc_port_hist #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          was_en,
  output logic          addr_moved
);
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_en    <= 1'b0;
      prev_addr <= '0;
    end else begin
      was_en    <= en;
      prev_addr <= addr;
    end
  end

  assign addr_moved = (addr != prev_addr);
endmodule

// File: rtl/dpc_owner.sv
module dpc_owner
  import dpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  coll,
  input  side_e fresh,
  output side_e owner
);
  side_e held_side;

  always_comb begin
    if (!coll)                       owner = SIDE_NONE;
    else if (held_side != SIDE_NONE) owner = held_side;
    else                             owner = fresh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_side <= SIDE_NONE;
    else        held_side <= owner;
  end
endmodule

// File: rtl/dpc_port_out.sv
module dpc_port_out (
  input  logic clk,
  input  logic rst_n,
  input  logic lose,
  input  logic en,
  input  logic wr,
  output logic busy_n,
  output logic wr_ok,
  output logic rd_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_n <= 1'b1;
      wr_ok  <= 1'b0;
      rd_ok  <= 1'b0;
    end else begin
      busy_n <= !lose;
      wr_ok  <= en && wr && !lose;
      rd_ok  <= en && !wr;
    end
  end
endmodule

// File: rtl/dpcoll_arb.sv
module dpcoll_arb
  import dpc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead_sel,
  input  logic          left_en,
  input  logic          left_wr,
  input  logic [AW-1:0] left_addr,
  input  logic          right_en,
  input  logic          right_wr,
  input  logic [AW-1:0] right_addr,
  input  logic          left_hold_in_n,
  input  logic          right_hold_in_n,
  output logic          left_busy_n,
  output logic          right_busy_n,
  output logic          left_wr_ok,
  output logic          right_wr_ok,
  output logic          left_rd_ok,
  output logic          right_rd_ok
);
  localparam int NP = 2;  // index 0 = left, 1 = right

  logic [NP-1:0] en_v, wr_v, was_en, moved, hold_n;
  logic [NP-1:0] lose_int, lose_eff, busy_v, wr_ok_v, rd_ok_v;
  logic [AW-1:0] addr_v [NP];
  logic          coll;
  side_e         fresh, owner;

  assign en_v   = {right_en, left_en};
  assign wr_v   = {right_wr, left_wr};
  assign hold_n = {right_hold_in_n, left_hold_in_n};
  assign addr_v[0] = left_addr;
  assign addr_v[1] = right_addr;

  for (genvar g = 0; g < NP; g++) begin : g_port
    dpc_port_hist #(.AW(AW)) u_hist (
      .clk(clk), .rst_n(rst_n), .en(en_v[g]), .addr(addr_v[g]),
      .was_en(was_en[g]), .addr_moved(moved[g])
    );
    dpc_port_out u_out (
      .clk(clk), .rst_n(rst_n), .lose(lose_eff[g]), .en(en_v[g]), .wr(wr_v[g]),
      .busy_n(busy_v[g]), .wr_ok(wr_ok_v[g]), .rd_ok(rd_ok_v[g])
    );
  end

  assign coll  = addr_hit(left_en, right_en, 64'(left_addr), 64'(right_addr));
  assign fresh = first_arrival(was_en[0], was_en[1], moved[0], moved[1]);

  dpc_owner u_owner (
    .clk(clk), .rst_n(rst_n), .coll(coll), .fresh(fresh), .owner(owner)
  );

  assign lose_int[0] = (owner == SIDE_RIGHT);
  assign lose_int[1] = (owner == SIDE_LEFT);
  assign lose_eff    = lead_sel ? lose_int : ~hold_n;

  assign left_busy_n  = busy_v[0];
  assign right_busy_n = busy_v[1];
  assign left_wr_ok   = wr_ok_v[0];
  assign right_wr_ok  = wr_ok_v[1];
  assign left_rd_ok   = rd_ok_v[0];
  assign right_rd_ok  = rd_ok_v[1];
endmodule

// File: rtl/dpc_arb_chk.sv
module dpc_arb_chk
  import dpc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  lead_sel,
  input logic  left_en,
  input logic  left_wr,
  input logic  right_en,
  input logic  right_wr,
  input logic  left_hold_in_n,
  input logic  right_hold_in_n,
  input logic  left_busy_n,
  input logic  right_busy_n,
  input logic  left_wr_ok,
  input logic  right_wr_ok,
  input logic  left_rd_ok,
  input logic  right_rd_ok,
  input logic  coll,
  input side_e owner
);
  p_one_loser_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lead_sel) |-> (left_busy_n || right_busy_n));

  p_busy_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lead_sel) && (!left_busy_n || !right_busy_n)) |-> $past(coll));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lead_sel) && !$past(coll)) |-> (left_busy_n && right_busy_n));

  p_keep_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && $past(coll)) |-> (owner == $past(owner)));

  p_wr_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(( !left_busy_n && left_wr_ok) || (!right_busy_n && right_wr_ok)));

  p_rd_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(left_en && !left_wr) |-> left_rd_ok);

  p_rd_pass_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(right_en && !right_wr) |-> right_rd_ok);

  p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lead_sel) |-> (left_busy_n == $past(left_hold_in_n)) &&
                         (right_busy_n == $past(right_hold_in_n)));
endmodule

bind dpcoll_arb dpc_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lead_sel(lead_sel),
  .left_en(left_en), .left_wr(left_wr), .right_en(right_en), .right_wr(right_wr),
  .left_hold_in_n(left_hold_in_n), .right_hold_in_n(right_hold_in_n),
  .left_busy_n(left_busy_n), .right_busy_n(right_busy_n),
  .left_wr_ok(left_wr_ok), .right_wr_ok(right_wr_ok),
  .left_rd_ok(left_rd_ok), .right_rd_ok(right_rd_ok),
  .coll(coll), .owner(owner)
);

// File: tb/sim_dpcoll_arb.sv
module sim_dpcoll_arb;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_sel = 1'b1;
  logic le = 0, lw = 0, re = 0, rw = 0;
  logic [AW-1:0] la = '0, ra = '0;
  logic lh = 1'b1, rh = 1'b1;
  logic lb, rb, lwo, rwo, lro, rro;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dpcoll_arb #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .lead_sel(lead_sel),
    .left_en(le), .left_wr(lw), .left_addr(la),
    .right_en(re), .right_wr(rw), .right_addr(ra),
    .left_hold_in_n(lh), .right_hold_in_n(rh),
    .left_busy_n(lb), .right_busy_n(rb),
    .left_wr_ok(lwo), .right_wr_ok(rwo),
    .left_rd_ok(lro), .right_rd_ok(rro)
  );

  // packed order: {left_busy_n, right_busy_n, left_wr_ok, right_wr_ok, left_rd_ok, right_rd_ok}
  task automatic drive(input logic l_en, input logic l_wr, input int l_a,
                       input logic r_en, input logic r_wr, input int r_a);
    le = l_en; lw = l_wr; la = AW'(l_a);
    re = r_en; rw = r_wr; ra = AW'(r_a);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] got;
    got = {lb, rb, lwo, rwo, lro, rro};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    drive(1, 1, 2, 1, 1, 2);
    step(); step();
    check("R10 reset outputs", 6'b110000);
    rst_n = 1'b1;

    // R5: both newly enabled on one address, left wins
    drive(1, 1, 2, 1, 1, 2); step();
    check("R5 simultaneous enable, left wins; R7 right write blocked", 6'b101000);
    idle();
    check("R2 release after enables drop", 6'b110000);

    // R3: left enabled first
    drive(1, 0, 5, 0, 0, 0); step();
    check("R8 lone read", 6'b110010);
    drive(1, 0, 5, 1, 1, 5); step();
    check("R3 left enabled first wins; R7 right write blocked", 6'b100010);
    drive(1, 0, 5, 1, 0, 5); step();
    check("R8 losing read passes, R6 held", 6'b100011);
    idle();

    // R3: right enabled first
    drive(0, 0, 0, 1, 0, 4); step();
    drive(1, 1, 4, 1, 0, 4); step();
    check("R3 right enabled first wins; R7 left write blocked", 6'b010001);
    idle();

    // R4: right moves onto left
    drive(1, 0, 1, 1, 0, 6); step();
    check("R1 no busy on different addresses", 6'b110011);
    drive(1, 0, 1, 1, 0, 1); step();
    check("R4 right moved, left wins", 6'b100011);
    idle();

    // R4: left moves onto right, then hold, release, re-collide
    drive(1, 0, 1, 1, 0, 6); step();
    drive(1, 1, 6, 1, 0, 6); step();
    check("R4 left moved, right wins; R7 left write blocked", 6'b010001);
    drive(1, 1, 6, 1, 1, 6); step();
    check("R6 winner held; R7 winner write passes", 6'b010100);
    drive(1, 1, 6, 1, 1, 7); step();
    check("R2 release on address mismatch", 6'b111100);
    drive(1, 1, 7, 1, 1, 7); step();
    check("R4 left moved onto right again", 6'b010100);
    drive(1, 1, 7, 0, 0, 7); step();
    check("R2 release when right enable drops", 6'b111000);
    idle();

    // R5: both addresses move together
    drive(1, 0, 1, 1, 0, 2); step();
    drive(1, 0, 3, 1, 0, 3); step();
    check("R5 both moved, left wins", 6'b100011);
    idle();

    // R9: follower mode
    lead_sel = 1'b0; lh = 1'b1; rh = 1'b1;
    drive(1, 1, 3, 1, 1, 3); step();
    check("R9 collision ignored in follower mode", 6'b111100);
    lh = 1'b0;
    drive(1, 1, 0, 0, 0, 0); step();
    check("R9 hold input blocks left write", 6'b010000);
    lh = 1'b1; rh = 1'b0;
    drive(0, 0, 0, 1, 0, 5); step();
    check("R9 right follows hold, R8 read passes", 6'b100001);
    lead_sel = 1'b1; rh = 1'b1;
    idle();
    check("R2 back in lead mode, idle", 6'b110000);

    // R1 sweep: every address pair, both newly enabled writers
    for (int a = 0; a < (1 << AW); a++) begin
      for (int b = 0; b < (1 << AW); b++) begin
        drive(1, 1, a, 1, 1, b); step();
        if (a == b) check($sformatf("R1 pair %0d,%0d collides", a, b), 6'b101000);
        else        check($sformatf("R1 pair %0d,%0d free", a, b), 6'b111100);
        idle();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule